// File: doc/BRIEF.md
# Bridge-Steered PWM Generator

This block builds one pulse-width-modulated waveform with a 10-bit duty resolution and places it on four drive pins, A to D. A free-running 10-bit count is made of an 8-bit coarse part and a 2-bit fine part. One PWM cycle lasts 4*(period+1) clocks. The duty value is given as an 8-bit coarse field plus a 2-bit fine field, and the output stays active for that many clocks at the start of each cycle.

A two-bit steering field picks how the waveform reaches the pins. It can drive one pin alone, or a complementary half-bridge pair with a programmable dead time. It can also drive a full bridge in the forward or the reverse direction, where one pin is modulated and the others sit at fixed levels. A four-bit mode field enables the generator and sets the active level independently for the A/C pair and the B/D pair. Pins the current steering does not use are released: their enable is low and their drive is 0. All pins are plain control outputs with no handshake, since no data stream enters or leaves the block.

Top module: `pwm_bridge_steer`

## Requirements
- R1: One PWM cycle lasts 4*(period+1) clocks, and the duty in clocks is the 10-bit value {duty_hi, duty_lo}. With mode 4'b1100 and steer 2'b00, drv[0] is high for exactly duty clocks in every cycle and rises once per cycle.
- R2: With steer 2'b00 only pin A (bit 0) is modulated, drv_en is 4'b0001, and drv[3:1] stays 0.
- R3: With steer 2'b01 (forward bridge) D (bit 3) is modulated, A is held at its active level, B and C are held at their inactive level, and drv_en is 4'b1111.
- R4: A new duty value takes effect only at the start of the next PWM cycle. A change made in the middle of a cycle leaves that cycle's pulse width unchanged.
- R5: With steer 2'b10 (half bridge) A carries the PWM and B its complement. The rising edge of each is delayed by `dead` clocks and the falling edge is not delayed, so A is active for duty-dead clocks and B for 4*(period+1)-duty-dead clocks per cycle. A and B are never active together, drv_en is 4'b0011, and C and D are released.
- R6: With steer 2'b11 (reverse bridge) B is modulated, C is held active, A and D are held inactive, and drv_en is 4'b1111.
- R7: mode[1]=1 makes A and C active-low, and mode[0]=1 makes B and D active-low. Held pins take the level matching their polarity.
- R8: A duty of 0 gives a pin that is always inactive. A duty of 4*(period+1) or more gives a pin that is always active.
- R9: When mode[3:2] is not 2'b11 (including 4'b0000), all pins are released one clock later (drv_en=0, drv=0) and the counters are cleared. After the block is enabled again, a fresh cycle starts with the current duty, and the modulated pin becomes active on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | 11xx enables the PWM; bit 1 inverts A/C, bit 0 inverts B/D; other codes idle the block |
| steer | input | 2 | Output steering: 00 single, 01 forward bridge, 10 half bridge, 11 reverse bridge |
| period | input | 8 | Coarse period; the cycle is 4*(period+1) clocks |
| duty_hi | input | 8 | Upper eight bits of the 10-bit duty |
| duty_lo | input | 2 | Lower two bits of the 10-bit duty |
| dead | input | 6 | Half-bridge dead time in clocks |
| drv | output | 4 | Pin drive levels, bit 0 = A to bit 3 = D |
| drv_en | output | 4 | Per-pin drive enable; 0 means released |

## Verification
The hardest case to reach from the pins is a duty write that lands inside a running cycle, because the old duty must keep governing that cycle. The stimulus waits at the falling clock edge until pin A rises, which marks a fresh cycle. It then rewrites the duty one clock later and measures the current pulse and the following pulse separately. Dead time is checked by counting active clocks on A and B over a whole cycle, and by counting the clocks in which both are active.

// File: rtl/pwm_bridge_pkg.sv
package pwm_bridge_pkg;
  typedef enum logic [1:0] {
    STEER_SINGLE = 2'b00,
    STEER_FWD    = 2'b01,
    STEER_HALF   = 2'b10,
    STEER_REV    = 2'b11
  } steer_e;
endpackage

// File: rtl/pwm_bridge_timebase.sv
module pwm_bridge_timebase #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [TMR_W-1:0]          period,
  input  logic [TMR_W+FINE_W-1:0]   duty,
  output logic                      pwm_q
);
  localparam int CNT_W = TMR_W + FINE_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_lat;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  // last clock of a cycle: coarse part equals period and fine part is full
  assign limit = {period, {FINE_W{1'b1}}};
  assign wrap  = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      duty_lat <= '0;
      pwm_q    <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      duty_lat <= duty;
      pwm_q    <= 1'b0;
    end else begin
      pwm_q <= (cnt < duty_lat);
      if (wrap) begin
        cnt      <= '0;
        duty_lat <= duty;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: the latched duty moves only at a cycle boundary
  p_duty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(duty_lat));
endmodule

// File: rtl/pwm_bridge_deadband.sv
module pwm_bridge_deadband #(
  parameter int DB_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DB_W-1:0] dead,
  input  logic            din,
  output logic            dout
);
  logic [DB_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      dout     <= 1'b0;
    end else if (!run || !din) begin
      wait_cnt <= '0;
      dout     <= 1'b0;
    end else if (wait_cnt >= dead) begin
      dout <= 1'b1;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R5: the falling edge passes with no added delay
  p_fall_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !din |=> !dout);
endmodule

// File: rtl/pwm_bridge_steer_map.sv
module pwm_bridge_steer_map
  import pwm_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  steer_e     steer,
  input  logic       inv_ac,
  input  logic       inv_bd,
  input  logic       pwm,
  input  logic       a_db,
  input  logic       b_db,
  output logic [3:0] drv,
  output logic [3:0] drv_en
);
  logic [3:0] act;
  logic [3:0] en;
  logic [3:0] inv_mask;

  assign inv_mask = {inv_bd, inv_ac, inv_bd, inv_ac};

  always_comb begin
    act = '0;
    en  = '0;
    case (steer)
      STEER_SINGLE: begin act[0] = pwm; en = 4'b0001; end
      STEER_FWD:    begin act = {pwm, 1'b0, 1'b0, 1'b1}; en = 4'b1111; end
      STEER_HALF:   begin act[1:0] = {b_db, a_db}; en = 4'b0011; end
      STEER_REV:    begin act = {1'b0, 1'b1, pwm, 1'b0}; en = 4'b1111; end
      default:      begin act = '0; en = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv    <= '0;
      drv_en <= '0;
    end else if (!run) begin
      drv    <= '0;
      drv_en <= '0;
    end else begin
      drv    <= (act ^ inv_mask) & en;
      drv_en <= en;
    end
  end

  // R9: idle releases every pin on the next clock
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (drv_en == 4'b0000 && drv == 4'b0000));

  // R3: forward bridge drives all four pins
  p_fwd_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && steer == STEER_FWD) |=> (drv_en == 4'b1111));
endmodule

// File: rtl/pwm_bridge_steer.sv
module pwm_bridge_steer
  import pwm_bridge_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int DB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic [1:0]        steer,
  input  logic [TMR_W-1:0]  period,
  input  logic [TMR_W-1:0]  duty_hi,
  input  logic [FINE_W-1:0] duty_lo,
  input  logic [DB_W-1:0]   dead,
  output logic [3:0]        drv,
  output logic [3:0]        drv_en
);
  localparam int CNT_W = TMR_W + FINE_W;

  logic             run;
  logic             pwm_q;
  logic [CNT_W-1:0] duty;
  logic [1:0]       db_in;
  logic [1:0]       db_out;

  assign run   = (mode[3:2] == 2'b11);
  assign duty  = {duty_hi, duty_lo};
  assign db_in = {~pwm_q, pwm_q};

  pwm_bridge_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period),
    .duty(duty), .pwm_q(pwm_q)
  );

  // index 0 feeds pin A (true phase), index 1 feeds pin B (complement)
  for (genvar g = 0; g < 2; g++) begin : g_db
    pwm_bridge_deadband #(.DB_W(DB_W)) u_db (
      .clk(clk), .rst_n(rst_n), .run(run), .dead(dead),
      .din(db_in[g]), .dout(db_out[g])
    );
  end

  pwm_bridge_steer_map u_map (
    .clk(clk), .rst_n(rst_n), .run(run), .steer(steer_e'(steer)),
    .inv_ac(mode[1]), .inv_bd(mode[0]), .pwm(pwm_q),
    .a_db(db_out[0]), .b_db(db_out[1]),
    .drv(drv), .drv_en(drv_en)
  );

  // R5: the two half-bridge phases are never active together
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_out[0] && db_out[1]));
endmodule

// File: tb/pwm_bridge_steer_test.sv
`timescale 1ns/1ps
module pwm_bridge_steer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic [1:0] steer = 2'b00;
  logic [7:0] period = 8'd0;
  logic [7:0] duty_hi = 8'd0;
  logic [1:0] duty_lo = 2'd0;
  logic [5:0] dead = 6'd0;
  logic [3:0] drv;
  logic [3:0] drv_en;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwm_bridge_steer uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .steer(steer), .period(period),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .dead(dead),
    .drv(drv), .drv_en(drv_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] m, input logic [1:0] s, input int p,
                       input int dh, input int dl, input int db);
    @(negedge clk);
    mode = m; steer = s; period = 8'(p);
    duty_hi = 8'(dh); duty_lo = 2'(dl); dead = 6'(db);
    repeat (8 * (p + 1) + 8) @(negedge clk);
  endtask

  task automatic count_high(input int idx, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (drv[idx]) c++;
    end
  endtask

  task automatic t_reset;
    chk("R9", "reset drv_en", int'(drv_en), 0);
    chk("R9", "reset drv", int'(drv), 0);
  endtask

  task automatic t_single;
    int c;
    int rises;
    logic prev;
    setup(4'b1100, 2'b00, 9, 3, 2, 0);
    count_high(0, 40, c);
    chk("R1", "single A high clocks P=9 D=14", c, 14);
    chk("R2", "single drv_en", int'(drv_en), 1);
    chk("R2", "single drv[3:1]", int'(drv[3:1]), 0);
    setup(4'b1100, 2'b00, 4, 1, 3, 0);
    count_high(0, 20, c);
    chk("R1", "single A high clocks P=4 D=7", c, 7);
    rises = 0;
    prev = drv[0];
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (drv[0] && !prev) rises++;
      prev = drv[0];
    end
    chk("R1", "rises in three cycles", rises, 3);
  endtask

  task automatic t_edges;
    int c;
    setup(4'b1100, 2'b00, 9, 0, 0, 0);
    count_high(0, 40, c);
    chk("R8", "duty 0", c, 0);
    setup(4'b1100, 2'b00, 9, 10, 0, 0);
    count_high(0, 40, c);
    chk("R8", "duty equal to cycle", c, 40);
    setup(4'b1100, 2'b00, 9, 255, 3, 0);
    count_high(0, 40, c);
    chk("R8", "duty 1023", c, 40);
  endtask

  task automatic t_latch;
    int w;
    setup(4'b1100, 2'b00, 9, 3, 2, 0);
    while (drv[0]) @(negedge clk);
    while (!drv[0]) @(negedge clk);
    duty_hi = 8'd6; duty_lo = 2'd0;
    w = 1;
    @(negedge clk);
    while (drv[0]) begin w++; @(negedge clk); end
    chk("R4", "pulse after mid-cycle write", w, 14);
    while (!drv[0]) @(negedge clk);
    w = 0;
    while (drv[0]) begin w++; @(negedge clk); end
    chk("R4", "next pulse uses new duty", w, 24);
  endtask

  task automatic t_fwd;
    int c;
    setup(4'b1100, 2'b01, 9, 3, 2, 0);
    chk("R3", "fwd drv_en", int'(drv_en), 15);
    count_high(0, 40, c); chk("R3", "fwd A held active", c, 40);
    count_high(1, 40, c); chk("R3", "fwd B held inactive", c, 0);
    count_high(2, 40, c); chk("R3", "fwd C held inactive", c, 0);
    count_high(3, 40, c); chk("R3", "fwd D modulated", c, 14);
  endtask

  task automatic t_rev;
    int c;
    setup(4'b1100, 2'b11, 9, 3, 2, 0);
    chk("R6", "rev drv_en", int'(drv_en), 15);
    count_high(0, 40, c); chk("R6", "rev A inactive", c, 0);
    count_high(1, 40, c); chk("R6", "rev B modulated", c, 14);
    count_high(2, 40, c); chk("R6", "rev C active", c, 40);
    count_high(3, 40, c); chk("R6", "rev D inactive", c, 0);
  endtask

  task automatic t_half;
    int c;
    int both;
    setup(4'b1100, 2'b10, 9, 3, 2, 0);
    chk("R5", "half drv_en", int'(drv_en), 3);
    count_high(0, 40, c); chk("R5", "half A dead 0", c, 14);
    count_high(1, 40, c); chk("R5", "half B dead 0", c, 26);
    setup(4'b1100, 2'b10, 9, 3, 2, 3);
    count_high(0, 40, c); chk("R5", "half A dead 3", c, 11);
    count_high(1, 40, c); chk("R5", "half B dead 3", c, 23);
    both = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (drv[0] && drv[1]) both++;
    end
    chk("R5", "A and B overlap clocks", both, 0);
    chk("R5", "half C/D released", int'(drv[3:2]), 0);
  endtask

  task automatic t_polarity;
    int c;
    setup(4'b1111, 2'b00, 9, 3, 2, 0);
    count_high(0, 40, c); chk("R7", "single A active-low", c, 26);
    setup(4'b1101, 2'b01, 9, 3, 2, 0);
    count_high(0, 40, c); chk("R7", "fwd A active-high held", c, 40);
    count_high(1, 40, c); chk("R7", "fwd B inactive level low-active", c, 40);
    count_high(2, 40, c); chk("R7", "fwd C inactive level", c, 0);
    count_high(3, 40, c); chk("R7", "fwd D active-low", c, 26);
  endtask

  task automatic t_off;
    int c;
    setup(4'b1100, 2'b01, 9, 3, 2, 0);
    mode = 4'b0000;
    @(negedge clk);
    chk("R9", "off drv_en", int'(drv_en), 0);
    chk("R9", "off drv", int'(drv), 0);
    steer = 2'b00;
    repeat (5) @(negedge clk);
    mode = 4'b1100;
    @(negedge clk);
    chk("R9", "restart A after 1 edge", int'(drv[0]), 0);
    @(negedge clk);
    chk("R9", "restart A after 2 edges", int'(drv[0]), 1);
    mode = 4'b1000;
    @(negedge clk);
    chk("R9", "compare-style code releases", int'(drv_en), 0);
    count_high(0, 40, c);
    chk("R9", "idle stays low", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_edges();
    t_latch();
    t_fwd();
    t_rev();
    t_half();
    t_polarity();
    t_off();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule